// File: doc/BRIEF.md
# Receive Frame Event Counters

This block watches the end of every received Ethernet frame and sorts frames that already matched the station's address filter into two classes of trouble: frames that were too short (runts) and frames that could not be kept (missed). Each class has an 8-bit host-readable counter. The counter wraps freely, and it marks the wrap with a single-cycle overflow pulse. An interrupt stage elsewhere uses that pulse.

Each class also has a second 8-bit register, the snapshot, which goes into per-frame status words. It counts the same events as the counter but stops at its maximum and keeps that value until a reset. A frame is missed for any of three reasons: the receive FIFO overflowed, the receiver was switched off, or too many received frames were still waiting for the host. When a frame is both short and missed, only the missed class counts it.

Top module: `rx_evt_counters`

## Requirements
- R1: A frame whose address-match input `addr_hit_i` is 0 at its end-of-frame strobe changes no counter, snapshot or overflow output.
- R2: A matching frame that is not missed counts as a runt when `byte_cnt_i` < 64. The runt counter then reads one higher in the cycle after the strobe. A count of 63 qualifies as a runt and a count of 64 does not.
- R3: A matching frame is missed when `fifo_ovf_i` is 1, when `rx_en_i` is 0, or when `pend_cnt_i` > 15. The missed counter then reads one higher in the cycle after the strobe. A pending count of 16 qualifies and a pending count of 15 does not.
- R4: A frame that qualifies as both runt and missed increments only the missed counter.
- R5: The counters are 8 bits wide and go from 255 to 0. The matching overflow output is 1 for exactly the one cycle in which the counter first reads 0 after the wrap, and 0 at all other times.
- R6: Each snapshot increments together with its counter until it reaches 255. After that it stays at 255 until a reset, including across a counter wrap.
- R7: `rst_ni` low (asynchronous) or `soft_rst_i` high at a clock edge clears both counters, both snapshots and both overflow outputs. The soft reset wins over a coincident frame.
- R8: No counter, snapshot or overflow output changes in a cycle after one in which `eof_i` was 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Synchronous software reset, active high |
| eof_i | input | 1 | End-of-frame strobe, one cycle per frame |
| byte_cnt_i | input | 11 | Data bytes received after the start delimiter |
| addr_hit_i | input | 1 | Frame passed address filtering |
| fifo_ovf_i | input | 1 | Frame lost to a receive FIFO overflow |
| rx_en_i | input | 1 | Receiver enabled |
| pend_cnt_i | input | 5 | Received frames pending for the host |
| runt_cnt_o | output | 8 | Wrapping runt counter |
| miss_cnt_o | output | 8 | Wrapping missed counter |
| runt_ovf_o | output | 1 | Runt counter wrap pulse |
| miss_ovf_o | output | 1 | Missed counter wrap pulse |
| runt_snap_o | output | 8 | Saturating runt snapshot |
| miss_snap_o | output | 8 | Saturating missed snapshot |

## Verification
The assertions assume that every frame input is valid in the cycle in which `eof_i` is high. They also assume that one strobe cycle stands for exactly one frame, so an `eof_i` held high for two cycles counts as two frames. The bench meets these assumptions by driving all frame fields and the strobe together on the falling edge, holding the strobe for exactly one cycle, and inserting an idle cycle between frames. Only the idle checks change the frame fields while the strobe is low, and they do so to show that those fields are ignored.

// File: rtl/rx_evt_pkg.sv
package rx_evt_pkg;
    // Event lanes served by the counter bank
    localparam int NUM_EV   = 2;
    localparam int EV_RUNT  = 0;
    localparam int EV_MISS  = 1;

    // Outcome of classifying one frame
    typedef enum logic [1:0] {
        FRM_IGNORE = 2'd0,
        FRM_RUNT   = 2'd1,
        FRM_MISS   = 2'd2
    } frm_class_e;
endpackage

// File: rtl/rx_frame_classify.sv
module rx_frame_classify
    import rx_evt_pkg::*;
#(
    parameter int BYTE_W     = 11,
    parameter int PEND_W     = 5,
    parameter int MIN_BYTES  = 64,
    parameter int PEND_LIMIT = 15
) (
    input  logic              eof_i,
    input  logic [BYTE_W-1:0] byte_cnt_i,
    input  logic              addr_hit_i,
    input  logic              fifo_ovf_i,
    input  logic              rx_en_i,
    input  logic [PEND_W-1:0] pend_cnt_i,
    output frm_class_e        class_o
);
    localparam logic [BYTE_W-1:0] SHORT_LIM = BYTE_W'(MIN_BYTES);
    localparam logic [PEND_W-1:0] PEND_MAX  = PEND_W'(PEND_LIMIT);

    logic eligible;
    logic lost;
    logic too_short;

    always_comb begin
        eligible  = eof_i && addr_hit_i;
        lost      = fifo_ovf_i || !rx_en_i || (pend_cnt_i > PEND_MAX);
        too_short = byte_cnt_i < SHORT_LIM;
        // A lost frame is charged to the missed class even when short
        if (!eligible)      class_o = FRM_IGNORE;
        else if (lost)      class_o = FRM_MISS;
        else if (too_short) class_o = FRM_RUNT;
        else                class_o = FRM_IGNORE;
    end
endmodule

// File: rtl/rx_evt_counter.sv
module rx_evt_counter #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o,
    output logic [W-1:0] snap_o
);
    localparam logic [W-1:0] TOP = '1;
    localparam logic [W-1:0] ONE = W'(1);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         wrap;
        logic [W-1:0] snap;
    } ctr_state_t;

    ctr_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.wrap = 1'b0;
        if (clr_i) begin
            st_d = '0;
        end else if (inc_i) begin
            st_d.cnt  = st_q.cnt + ONE;
            st_d.wrap = (st_q.cnt == TOP);
            if (st_q.snap != TOP) begin
                st_d.snap = st_q.snap + ONE;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cnt_o  = st_q.cnt;
    assign wrap_o = st_q.wrap;
    assign snap_o = st_q.snap;
endmodule

// File: rtl/rx_evt_counters.sv
module rx_evt_counters
    import rx_evt_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int BYTE_W     = 11,
    parameter int PEND_W     = 5,
    parameter int MIN_BYTES  = 64,
    parameter int PEND_LIMIT = 15
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              soft_rst_i,
    input  logic              eof_i,
    input  logic [BYTE_W-1:0] byte_cnt_i,
    input  logic              addr_hit_i,
    input  logic              fifo_ovf_i,
    input  logic              rx_en_i,
    input  logic [PEND_W-1:0] pend_cnt_i,
    output logic [CNT_W-1:0]  runt_cnt_o,
    output logic [CNT_W-1:0]  miss_cnt_o,
    output logic              runt_ovf_o,
    output logic              miss_ovf_o,
    output logic [CNT_W-1:0]  runt_snap_o,
    output logic [CNT_W-1:0]  miss_snap_o
);
    frm_class_e             frm_class;
    logic [NUM_EV-1:0]      ev_inc;
    logic [CNT_W-1:0]       ev_cnt  [NUM_EV];
    logic [CNT_W-1:0]       ev_snap [NUM_EV];
    logic [NUM_EV-1:0]      ev_wrap;

    rx_frame_classify #(
        .BYTE_W    (BYTE_W),
        .PEND_W    (PEND_W),
        .MIN_BYTES (MIN_BYTES),
        .PEND_LIMIT(PEND_LIMIT)
    ) u_classify (
        .eof_i     (eof_i),
        .byte_cnt_i(byte_cnt_i),
        .addr_hit_i(addr_hit_i),
        .fifo_ovf_i(fifo_ovf_i),
        .rx_en_i   (rx_en_i),
        .pend_cnt_i(pend_cnt_i),
        .class_o   (frm_class)
    );

    always_comb begin
        ev_inc          = '0;
        ev_inc[EV_RUNT] = (frm_class == FRM_RUNT);
        ev_inc[EV_MISS] = (frm_class == FRM_MISS);
    end

    for (genvar g = 0; g < NUM_EV; g++) begin : g_lane
        rx_evt_counter #(.W(CNT_W)) u_ctr (
            .clk_i (clk_i),
            .rst_ni(rst_ni),
            .clr_i (soft_rst_i),
            .inc_i (ev_inc[g]),
            .cnt_o (ev_cnt[g]),
            .wrap_o(ev_wrap[g]),
            .snap_o(ev_snap[g])
        );
    end

    assign runt_cnt_o  = ev_cnt[EV_RUNT];
    assign miss_cnt_o  = ev_cnt[EV_MISS];
    assign runt_ovf_o  = ev_wrap[EV_RUNT];
    assign miss_ovf_o  = ev_wrap[EV_MISS];
    assign runt_snap_o = ev_snap[EV_RUNT];
    assign miss_snap_o = ev_snap[EV_MISS];
endmodule

// File: rtl/rx_evt_counters_chk.sv
module rx_evt_counters_chk #(
    parameter int CNT_W      = 8,
    parameter int BYTE_W     = 11,
    parameter int PEND_W     = 5,
    parameter int MIN_BYTES  = 64,
    parameter int PEND_LIMIT = 15
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              soft_rst_i,
    input logic              eof_i,
    input logic [BYTE_W-1:0] byte_cnt_i,
    input logic              addr_hit_i,
    input logic              fifo_ovf_i,
    input logic              rx_en_i,
    input logic [PEND_W-1:0] pend_cnt_i,
    input logic [CNT_W-1:0]  runt_cnt_o,
    input logic [CNT_W-1:0]  miss_cnt_o,
    input logic              runt_ovf_o,
    input logic              miss_ovf_o,
    input logic [CNT_W-1:0]  runt_snap_o,
    input logic [CNT_W-1:0]  miss_snap_o
);
    localparam logic [CNT_W-1:0] FULL = '1;

    logic lost_now;
    logic short_now;
    assign lost_now  = fifo_ovf_i || !rx_en_i || (int'(pend_cnt_i) > PEND_LIMIT);
    assign short_now = int'(byte_cnt_i) < MIN_BYTES;

    assert_no_change_nohit_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eof_i && !addr_hit_i && !soft_rst_i) |=>
            ($stable(runt_cnt_o) && $stable(miss_cnt_o)))
        else $error("R1 violated");

    assert_runt_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eof_i && addr_hit_i && !lost_now && short_now && !soft_rst_i) |=>
            (runt_cnt_o == CNT_W'($past(runt_cnt_o) + 1'b1)) && $stable(miss_cnt_o))
        else $error("R2 violated");

    // R4 is covered here too: a lost frame never moves the runt counter
    assert_miss_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eof_i && addr_hit_i && lost_now && !soft_rst_i) |=>
            (miss_cnt_o == CNT_W'($past(miss_cnt_o) + 1'b1)) && $stable(runt_cnt_o))
        else $error("R3 violated");

    assert_runt_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        runt_ovf_o |-> (runt_cnt_o == '0) && ($past(runt_cnt_o) == FULL))
        else $error("R5 violated (runt)");

    assert_miss_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        miss_ovf_o |-> (miss_cnt_o == '0) && ($past(miss_cnt_o) == FULL))
        else $error("R5 violated (miss)");

    assert_snap_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (runt_snap_o == FULL && !soft_rst_i) |=> (runt_snap_o == FULL))
        else $error("R6 violated");

    assert_soft_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        soft_rst_i |=> (runt_cnt_o == '0) && (miss_cnt_o == '0) &&
                       (runt_snap_o == '0) && (miss_snap_o == '0) &&
                       !runt_ovf_o && !miss_ovf_o)
        else $error("R7 violated");

    assert_idle_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!eof_i && !soft_rst_i) |=>
            ($stable(runt_cnt_o) && $stable(miss_cnt_o) &&
             $stable(runt_snap_o) && $stable(miss_snap_o) &&
             !runt_ovf_o && !miss_ovf_o))
        else $error("R8 violated");
endmodule

bind rx_evt_counters rx_evt_counters_chk #(
    .CNT_W     (CNT_W),
    .BYTE_W    (BYTE_W),
    .PEND_W    (PEND_W),
    .MIN_BYTES (MIN_BYTES),
    .PEND_LIMIT(PEND_LIMIT)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst_i),
    .eof_i      (eof_i),
    .byte_cnt_i (byte_cnt_i),
    .addr_hit_i (addr_hit_i),
    .fifo_ovf_i (fifo_ovf_i),
    .rx_en_i    (rx_en_i),
    .pend_cnt_i (pend_cnt_i),
    .runt_cnt_o (runt_cnt_o),
    .miss_cnt_o (miss_cnt_o),
    .runt_ovf_o (runt_ovf_o),
    .miss_ovf_o (miss_ovf_o),
    .runt_snap_o(runt_snap_o),
    .miss_snap_o(miss_snap_o)
);

// File: tb/sim_rx_evt_counters.sv
`timescale 1ns/1ps
module sim_rx_evt_counters;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        eof = 1'b0;
    logic [10:0] bytes = '0;
    logic        hit = 1'b0;
    logic        fovf = 1'b0;
    logic        ren = 1'b1;
    logic [4:0]  pend = '0;
    logic [7:0]  runt_cnt, miss_cnt, runt_snap, miss_snap;
    logic        runt_ovf, miss_ovf;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    int exp_runt = 0, exp_miss = 0, exp_rsnap = 0, exp_msnap = 0;

    always #2.5 clk = ~clk;

    rx_evt_counters u0 (
        .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst), .eof_i(eof),
        .byte_cnt_i(bytes), .addr_hit_i(hit), .fifo_ovf_i(fovf), .rx_en_i(ren),
        .pend_cnt_i(pend), .runt_cnt_o(runt_cnt), .miss_cnt_o(miss_cnt),
        .runt_ovf_o(runt_ovf), .miss_ovf_o(miss_ovf),
        .runt_snap_o(runt_snap), .miss_snap_o(miss_snap)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check(req, "runt_cnt",  int'(runt_cnt),  exp_runt % 256);
        check(req, "miss_cnt",  int'(miss_cnt),  exp_miss % 256);
        check(req, "runt_snap", int'(runt_snap), exp_rsnap);
        check(req, "miss_snap", int'(miss_snap), exp_msnap);
    endtask

    // Independent model of the classification, applied to bench state
    task automatic model(input bit h, input int b, input bit fo, input bit en, input int p);
        bit lost;
        lost = fo || !en || (p > 15);
        if (h && lost) begin
            exp_miss++;
            if (exp_msnap < 255) exp_msnap++;
        end else if (h && b < 64) begin
            exp_runt++;
            if (exp_rsnap < 255) exp_rsnap++;
        end
    endtask

    // One frame: strobe for one cycle, then one idle cycle; outputs sampled on falling edges
    task automatic frame(input bit h, input int b, input bit fo, input bit en, input int p);
        @(negedge clk);
        eof = 1'b1; hit = h; bytes = 11'(b); fovf = fo; ren = en; pend = 5'(p);
        @(negedge clk);
        eof = 1'b0; hit = 1'b0; fovf = 1'b0; ren = 1'b1; pend = '0; bytes = '0;
        model(h, b, fo, en, p);
    endtask

    task automatic t_reset_state;
        check_all("R7");
        check("R7", "runt_ovf", int'(runt_ovf), 0);
        check("R7", "miss_ovf", int'(miss_ovf), 0);
    endtask

    task automatic t_nohit;
        frame(1'b0, 10, 1'b0, 1'b1, 0);
        frame(1'b0, 10, 1'b1, 1'b0, 20);
        check_all("R1");
    endtask

    task automatic t_runt_edge;
        frame(1'b1, 63, 1'b0, 1'b1, 0);
        check_all("R2");
        frame(1'b1, 64, 1'b0, 1'b1, 0);
        check_all("R2");
        frame(1'b1, 0, 1'b0, 1'b1, 15);
        check_all("R2");
    endtask

    task automatic t_miss_causes;
        frame(1'b1, 500, 1'b1, 1'b1, 0);
        check_all("R3");
        frame(1'b1, 500, 1'b0, 1'b0, 0);
        check_all("R3");
        frame(1'b1, 500, 1'b0, 1'b1, 16);
        check_all("R3");
        frame(1'b1, 500, 1'b0, 1'b1, 15);
        check_all("R3");
    endtask

    task automatic t_both;
        frame(1'b1, 20, 1'b1, 1'b1, 0);
        frame(1'b1, 20, 1'b0, 1'b1, 31);
        check_all("R4");
    endtask

    task automatic t_idle;
        @(negedge clk);
        hit = 1'b1; bytes = 11'd5; fovf = 1'b1; ren = 1'b0; pend = 5'd31;
        repeat (3) @(negedge clk);
        hit = 1'b0; bytes = '0; fovf = 1'b0; ren = 1'b1; pend = '0;
        @(negedge clk);
        check_all("R8");
        check("R8", "runt_ovf", int'(runt_ovf), 0);
    endtask

    task automatic t_wrap;
        while (exp_runt < 255) frame(1'b1, 1, 1'b0, 1'b1, 0);
        check("R5", "runt_cnt at 255", int'(runt_cnt), 255);
        check("R5", "no pulse at 255", int'(runt_ovf), 0);
        check("R6", "snap at 255", int'(runt_snap), 255);
        @(negedge clk);
        eof = 1'b1; hit = 1'b1; bytes = 11'd1;
        @(negedge clk);
        eof = 1'b0; hit = 1'b0; bytes = '0;
        model(1'b1, 1, 1'b0, 1'b1, 0);
        check("R5", "wrap pulse", int'(runt_ovf), 1);
        check("R5", "runt_cnt after wrap", int'(runt_cnt), 0);
        check("R5", "miss pulse quiet", int'(miss_ovf), 0);
        check("R6", "snap sticks", int'(runt_snap), 255);
        @(negedge clk);
        check("R5", "pulse one cycle", int'(runt_ovf), 0);
        frame(1'b1, 1, 1'b0, 1'b1, 0);
        check_all("R6");
    endtask

    task automatic t_soft_reset;
        @(negedge clk);
        soft_rst = 1'b1; eof = 1'b1; hit = 1'b1; fovf = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0; eof = 1'b0; hit = 1'b0; fovf = 1'b0;
        exp_runt = 0; exp_miss = 0; exp_rsnap = 0; exp_msnap = 0;
        check_all("R7");
        frame(1'b1, 3, 1'b0, 1'b1, 0);
        check_all("R7");
        #1.3 rst_n = 1'b0;
        #1.0;
        exp_runt = 0; exp_rsnap = 0;
        check_all("R7");
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #20000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_nohit();
        t_runt_edge();
        t_miss_causes();
        t_both();
        t_idle();
        t_wrap();
        t_soft_reset();
        finish_run();
    end
endmodule